// File: doc/BRIEF.md
# Shared-Butterfly 4x4 Forward Integer Transform

This block turns a 4x4 residual block into 16 transform coefficients. A mode input selects the transform. One choice is the integer core transform built from the rows [1 1 1 1], [2 1 -1 -2], [1 -1 -1 1] and [1 -2 2 -1]. The other choice is the 4x4 Hadamard transform, which takes the same matrix with every factor of two replaced by one and keeps every sign. In both modes the result is Y = C·X·Cᵀ. Both modes run on the same adder network. The datapath first makes a row pass of four butterflies and then a column pass of four more. Each butterfly forms the sum and the difference of inputs 0 and 3 and of inputs 1 and 2, then combines them. The doubling needed in the core transform is a one-bit shift, so the block uses no multiplier.

A source presents all sixteen 9-bit signed residuals in one clock together with a valid strobe. The block returns the result as two beats of eight 16-bit signed coefficients on consecutive clocks, so it can take a new block every second clock.

Top module: `xf4_top`

## Requirements
- R1: After reset, out_valid and out_last are 0 and in_ready is 1.
- R2: With in_hadamard = 0, the coefficients equal C·X·Cᵀ exactly for the core matrix above. Input sample X[r][c] is taken from in_blk bits [(4r+c)·9 +: 9] as a two's-complement value.
- R3: With in_hadamard = 1, the coefficients equal H·X·Hᵀ exactly. H is the core matrix with every ±2 replaced by ±1.
- R4: A block is accepted on a rising edge when in_valid and in_ready are both 1. In the following cycle out_valid = 1 and out_last = 0. Output slot n = 4r+c (bits [n·16 +: 16]) then holds Y[r][c] for rows 0 and 1.
- R5: In the cycle after the first beat, out_valid = 1 and out_last = 1. Slot n = 4(r−2)+c then holds Y[r][c] for rows 2 and 3.
- R6: in_ready is 0 while the first beat is on the outputs. A block offered then is ignored: the second beat still carries the earlier block, and no extra beat follows.
- R7: If a new block is offered in the cycle that shows the second beat, it is accepted. out_valid then stays 1 with no gap between blocks.
- R8: When no block is accepted and no second beat is pending, out_valid is 0 on the next cycle.
- R9: The mode is captured together with each block. Consecutive blocks in different modes are each transformed in their own mode.
- R10: Inputs at the extremes of the 9-bit range (all −256, all +255, alternating signs) give exact results with no wrap in the 16-bit outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A block is offered on in_blk |
| in_ready | output | 1 | Block can accept an input this cycle |
| in_hadamard | input | 1 | 1 selects Hadamard, 0 selects the core integer transform |
| in_blk | input | 144 | Sixteen 9-bit signed residuals, raster order |
| out_valid | output | 1 | A result beat is on out_coef |
| out_last | output | 1 | The beat on out_coef is the second beat of the block |
| out_coef | output | 128 | Eight 16-bit signed coefficients (two result rows) |

## Verification
The hardest case to reach from the ports is an offer that arrives while in_ready is low, because the first beat is being shown. That offer must be dropped without disturbing the pending second beat. The bench gets there by holding in_valid high with different data through the first-beat cycle. It then checks that the second beat still matches the original block and that out_valid falls afterwards. In other runs the bench offers the next block exactly on the second-beat cycle, in the other mode, to check gap-free back-to-back operation. Impulses at all sixteen positions, in both modes, check every matrix coefficient one at a time.

// File: rtl/xf4_pkg.sv
package xf4_pkg;
    localparam int XF_SIDE = 4;
    localparam int XF_SAMPLES = XF_SIDE * XF_SIDE;
    localparam int XF_BEAT = XF_SAMPLES / 2;

    typedef enum logic {
        XF_CORE = 1'b0,
        XF_HAD  = 1'b1
    } xf_mode_e;
endpackage

// File: rtl/xf4_bfly.sv
module xf4_bfly #(
    parameter int W_IN  = 9,
    parameter int W_OUT = 12
) (
    input  logic                    dbl,
    input  logic signed [W_IN-1:0]  x0,
    input  logic signed [W_IN-1:0]  x1,
    input  logic signed [W_IN-1:0]  x2,
    input  logic signed [W_IN-1:0]  x3,
    output logic signed [W_OUT-1:0] y0,
    output logic signed [W_OUT-1:0] y1,
    output logic signed [W_OUT-1:0] y2,
    output logic signed [W_OUT-1:0] y3
);
    logic signed [W_OUT-1:0] e0, e1, e2, e3;
    logic signed [W_OUT-1:0] s_out, s_in, d_out, d_in;

    always_comb begin
        e0 = W_OUT'(x0);
        e1 = W_OUT'(x1);
        e2 = W_OUT'(x2);
        e3 = W_OUT'(x3);
        // outer and inner pairs
        s_out = e0 + e3;
        s_in  = e1 + e2;
        d_out = e0 - e3;
        d_in  = e1 - e2;
        y0 = s_out + s_in;
        y2 = s_out - s_in;
        y1 = (dbl ? (d_out <<< 1) : d_out) + d_in;
        y3 = d_out - (dbl ? (d_in <<< 1) : d_in);
    end
endmodule

// File: rtl/xf4_pass.sv
module xf4_pass
    import xf4_pkg::*;
#(
    parameter int W_IN  = 9,
    parameter int W_OUT = 12,
    parameter bit COLS  = 1'b0
) (
    input  logic                          dbl,
    input  logic [XF_SAMPLES*W_IN-1:0]    din,
    output logic [XF_SAMPLES*W_OUT-1:0]   dout
);
    localparam int STEP = COLS ? XF_SIDE : 1;

    for (genvar l = 0; l < XF_SIDE; l++) begin : g_lane
        localparam int BASE = COLS ? l : l * XF_SIDE;
        xf4_bfly #(
            .W_IN (W_IN),
            .W_OUT(W_OUT)
        ) u_bfly (
            .dbl(dbl),
            .x0 (din[(BASE + 0*STEP)*W_IN +: W_IN]),
            .x1 (din[(BASE + 1*STEP)*W_IN +: W_IN]),
            .x2 (din[(BASE + 2*STEP)*W_IN +: W_IN]),
            .x3 (din[(BASE + 3*STEP)*W_IN +: W_IN]),
            .y0 (dout[(BASE + 0*STEP)*W_OUT +: W_OUT]),
            .y1 (dout[(BASE + 1*STEP)*W_OUT +: W_OUT]),
            .y2 (dout[(BASE + 2*STEP)*W_OUT +: W_OUT]),
            .y3 (dout[(BASE + 3*STEP)*W_OUT +: W_OUT])
        );
    end
endmodule

// File: rtl/xf4_top.sv
module xf4_top
    import xf4_pkg::*;
#(
    parameter int IN_W  = 9,
    parameter int OUT_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic                       in_hadamard,
    input  logic [XF_SAMPLES*IN_W-1:0] in_blk,
    output logic                       out_valid,
    output logic                       out_last,
    output logic [XF_BEAT*OUT_W-1:0]   out_coef
);
    localparam int MID_W  = IN_W + 3;
    localparam int BEAT_W = XF_BEAT * OUT_W;

    typedef struct packed {
        logic              pend;
        logic              ov;
        logic              ol;
        logic [BEAT_W-1:0] cur;
        logic [BEAT_W-1:0] hold;
    } st_t;

    st_t st_d, st_q;

    xf_mode_e                      mode;
    logic                          dbl;
    logic                          accept;
    logic [XF_SAMPLES*MID_W-1:0]   rows_y;
    logic [XF_SAMPLES*OUT_W-1:0]   blk_y;

    assign mode = xf_mode_e'(in_hadamard);
    assign dbl  = (mode == XF_CORE);

    xf4_pass #(
        .W_IN (IN_W),
        .W_OUT(MID_W),
        .COLS (1'b0)
    ) u_row_pass (
        .dbl (dbl),
        .din (in_blk),
        .dout(rows_y)
    );

    xf4_pass #(
        .W_IN (MID_W),
        .W_OUT(OUT_W),
        .COLS (1'b1)
    ) u_col_pass (
        .dbl (dbl),
        .din (rows_y),
        .dout(blk_y)
    );

    assign in_ready = !st_q.pend;
    assign accept   = in_valid && in_ready;

    always_comb begin
        st_d    = st_q;
        st_d.ov = 1'b0;
        st_d.ol = 1'b0;
        if (st_q.pend) begin
            st_d.cur  = st_q.hold;
            st_d.ov   = 1'b1;
            st_d.ol   = 1'b1;
            st_d.pend = 1'b0;
        end else if (accept) begin
            st_d.cur  = blk_y[BEAT_W-1:0];
            st_d.hold = blk_y[2*BEAT_W-1:BEAT_W];
            st_d.ov   = 1'b1;
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.ov;
    assign out_last  = st_q.ol;
    assign out_coef  = st_q.cur;
endmodule

// File: rtl/xf4_chk.sv
module xf4_chk
    import xf4_pkg::*;
#(
    parameter int IN_W  = 9,
    parameter int OUT_W = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       in_valid,
    input logic                       in_ready,
    input logic [XF_SAMPLES*IN_W-1:0] in_blk,
    input logic                       out_valid,
    input logic                       out_last,
    input logic [XF_BEAT*OUT_W-1:0]   out_coef
);
    logic signed [OUT_W-1:0] sum_in;
    logic                    took;

    assign took = in_valid && in_ready;

    always_comb begin
        sum_in = '0;
        for (int k = 0; k < XF_SAMPLES; k++) begin
            sum_in = sum_in + OUT_W'($signed(in_blk[k*IN_W +: IN_W]));
        end
    end

    // DC term is the plain sum of all samples in either mode (R2, R3)
    assert_dc_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
        took |=> ($signed(out_coef[OUT_W-1:0]) == $past(sum_in)));

    assert_first_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        took |=> (out_valid && !out_last));

    assert_second_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> (out_valid && out_last));

    assert_ready_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |-> !in_ready);

    assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!took && !(out_valid && !out_last)) |=> !out_valid);

    assert_last_needs_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
endmodule

bind xf4_top xf4_chk #(
    .IN_W (IN_W),
    .OUT_W(OUT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_blk   (in_blk),
    .out_valid(out_valid),
    .out_last (out_last),
    .out_coef (out_coef)
);

// File: tb/xf4_top_tb.sv
module xf4_top_tb;
    localparam int IN_W  = 9;
    localparam int OUT_W = 16;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic                 in_ready;
    logic                 in_hadamard = 1'b0;
    logic [16*IN_W-1:0]   in_blk = '0;
    logic                 out_valid;
    logic                 out_last;
    logic [8*OUT_W-1:0]   out_coef;

    int n_tests = 0;
    int n_fail  = 0;
    int unsigned seed = 32'h1234_5678;

    always #2ns clk = ~clk;

    xf4_top #(.IN_W(IN_W), .OUT_W(OUT_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_hadamard(in_hadamard),
        .in_blk     (in_blk),
        .out_valid  (out_valid),
        .out_last   (out_last),
        .out_coef   (out_coef)
    );

    function automatic int cm(bit had, int i, int k);
        int m[4][4] = '{'{1, 1, 1, 1}, '{2, 1, -1, -2}, '{1, -1, -1, 1}, '{1, -2, 2, -1}};
        int v = m[i][k];
        if (had && (v == 2 || v == -2)) v = v / 2;
        return v;
    endfunction

    function automatic int ref_y(bit had, int x[16], int i, int j);
        int acc = 0;
        for (int k = 0; k < 4; k++)
            for (int l = 0; l < 4; l++)
                acc += cm(had, i, k) * x[k*4+l] * cm(had, j, l);
        return acc;
    endfunction

    function automatic int slot(int n);
        return int'($signed(out_coef[n*OUT_W +: OUT_W]));
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(bit had, int x[16]);
        in_valid    = 1'b1;
        in_hadamard = had;
        for (int k = 0; k < 16; k++) in_blk[k*IN_W +: IN_W] = x[k][IN_W-1:0];
    endtask

    task automatic check_beat(bit had, int x[16], int half, string req);
        int bad = 0, act = 0, exp = 0;
        for (int n = 0; n < 8; n++) begin
            int e = ref_y(had, x, half*2 + n/4, n%4);
            if (slot(n) != e && bad == 0) begin
                bad = 1; act = slot(n); exp = e;
            end
        end
        check(bad == 0, req, act, exp);
    endtask

    // Called at a negedge with in_ready high; returns at the negedge showing the second beat.
    task automatic do_block(bit had, int x[16], bit press, string tag);
        int junk[16];
        string mreq;
        mreq = had ? "R3" : "R2";
        drive(had, x);
        @(posedge clk); @(negedge clk);
        check(out_valid && !out_last, {"R4 first beat flags ", tag}, {out_valid, out_last}, 2);
        check_beat(had, x, 0, {mreq, " R4 rows0-1 ", tag});
        check(!in_ready, "R6 ready low on first beat", in_ready, 0);
        if (press) begin
            for (int k = 0; k < 16; k++) junk[k] = 100 - 13 * k;
            drive(!had, junk);
        end else begin
            in_valid = 1'b0;
        end
        @(posedge clk); @(negedge clk);
        check(out_valid && out_last, {"R5 second beat flags ", tag}, {out_valid, out_last}, 3);
        check_beat(had, x, 1, {mreq, " R5 rows2-3 ", tag});
        in_valid = 1'b0;
    endtask

    task automatic idle_check(string req);
        @(posedge clk); @(negedge clk);
        check(!out_valid, req, out_valid, 0);
    endtask

    function automatic int rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 16) % 512) - 256;
    endfunction

    initial begin
        int x[16];
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(!out_valid && !out_last && in_ready, "R1 reset state",
              {out_valid, out_last, in_ready}, 1);

        // impulses at every position, both modes; every other one pressed during first beat
        for (int m = 0; m < 2; m++) begin
            for (int p = 0; p < 16; p++) begin
                for (int k = 0; k < 16; k++) x[k] = (k == p) ? 1 + p : 0;
                do_block(m[0], x, p[0], "impulse");
                idle_check(p[0] ? "R6 ignored offer adds no beat" : "R8 idle after block");
            end
        end

        // random blocks back to back, alternating mode (R7, R9)
        for (int b = 0; b < 60; b++) begin
            for (int k = 0; k < 16; k++) x[k] = rnd();
            do_block(b[0], x, 1'b0, "R7 R9 back-to-back");
        end
        idle_check("R8 idle after stream");

        // extremes (R10)
        for (int m = 0; m < 2; m++) begin
            for (int k = 0; k < 16; k++) x[k] = -256;
            do_block(m[0], x, 1'b0, "R10 all min");
            for (int k = 0; k < 16; k++) x[k] = 255;
            do_block(m[0], x, 1'b0, "R10 all max");
            for (int k = 0; k < 16; k++) x[k] = (((k / 4) + (k % 4)) % 2 == 0) ? 255 : -256;
            do_block(m[0], x, 1'b0, "R10 checker");
            for (int k = 0; k < 16; k++) x[k] = ((k % 4) == 1 || (k % 4) == 2) ? -256 : 255;
            do_block(m[0], x, 1'b0, "R10 column pattern");
            for (int k = 0; k < 16; k++) x[k] = (((k / 4) == 0 || (k / 4) == 3) == ((k % 4) == 0 || (k % 4) == 3)) ? 255 : -256;
            do_block(m[0], x, 1'b0, "R10 inner-outer");
        end
        idle_check("R8 idle at end");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule